// File: doc/BRIEF.md
# I2C bit-level arbitration tracker

This block sits beside a bit-at-a-time I2C engine. It owns the transmit-enable state and watches the bus for lost arbitration. Software strobes arm transmission: a data-register write, a send-start request or a send-stop request. Other strobes disarm it: a data-register read or an explicit clear. While armed, the block pulls SDA low according to what the local side is sending. That can be a data bit, a repeated start or a stop.

SDA and SCL are brought in through a synchronizer, and edges are taken on the synchronized values. The block flags arbitration loss when the bus shows something other than what the local side is driving. Four collision patterns are covered: a data or repeated-start mismatch at the SCL rising edge, a foreign repeated start that cuts into a transmitted 1, a repeated start pre-empted by another master's SCL low, and a stop blocked by a foreign 0. A loss drops the transmit-enable at once. The loss flag stays set until software clears it. SCL generation, byte shifting and address matching are handled elsewhere.

Top module: `i2c_arb_tracker`

## Requirements
- R1: After reset, `tx_active`, `arb_lost`, `sda_pull` and `start_det` are all 0.
- R2: A one-cycle strobe on `dat_wr`, `send_start` or `send_stop` sets `tx_active` at the next clock edge.
- R3: A strobe on `dat_rd` or `clr_txact` clears `tx_active` at the next clock edge. If a set strobe comes in the same cycle, the set wins.
- R4: `sda_pull` is 1 only while `tx_active` is 1, and it follows `tx_kind`. Kind 0 (data bit) pulls when `tx_bit` is 0. Kind 1 (repeated start) pulls while synchronized SCL is high. Kind 2 (stop) pulls while synchronized SCL is low. Kind 3 never pulls.
- R5: `arb_lost` can only be set while `tx_active` is 1. Every loss pattern is ignored when `tx_active` is 0.
- R6: With kind 0 and `tx_bit`=1, or with kind 1, a rising SCL edge seen while SDA is low sets `arb_lost`. A rising SCL edge with SDA high does not.
- R7: A start condition is SDA falling while SCL stays high. Every start condition gives a one-cycle `start_det` pulse. With kind 0 and `tx_bit`=1, a start condition also sets `arb_lost`.
- R8: With `master_mode`=1 and kind 1, a falling SCL edge seen while SDA is still high sets `arb_lost`. With `master_mode`=0 this has no effect.
- R9: With `master_mode`=1 and kind 2, a falling SCL edge seen while SDA is low sets `arb_lost`. A falling SCL edge with SDA high does not.
- R10: Setting `arb_lost` clears `tx_active` at the same edge. While `arb_lost` is 1, set strobes leave `tx_active` at 0.
- R11: `clr_arbloss` clears `arb_lost` at the next edge. A loss event in the same cycle wins over the clear.
- R12: A line change on `sda_in` or `scl_in` reaches `arb_lost` and `start_det` exactly three clock edges later: two synchronizer stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| tx_kind | input | 2 | What is being sent: 0 data bit, 1 repeated start, 2 stop |
| tx_bit | input | 1 | Data bit value for kind 0 |
| master_mode | input | 1 | Local side currently owns the bus as master |
| dat_wr | input | 1 | Data-register write strobe (arms transmit) |
| dat_rd | input | 1 | Data-register read strobe (disarms transmit) |
| send_start | input | 1 | Send-start request strobe (arms transmit) |
| send_stop | input | 1 | Send-stop request strobe (arms transmit) |
| clr_txact | input | 1 | Clear transmit-active strobe |
| clr_arbloss | input | 1 | Clear arbitration-loss strobe |
| sda_pull | output | 1 | Open-drain SDA pull-down enable |
| tx_active | output | 1 | Transmit-active flag |
| arb_lost | output | 1 | Arbitration-loss flag |
| start_det | output | 1 | One-cycle pulse per detected start condition |

## Verification
The results of this block have different latencies. A strobe changes `tx_active` one edge later. `sda_pull` follows `tx_kind`, `tx_bit` and `tx_active` in the same cycle. A raw line change reaches `arb_lost` and `start_det` three edges later. The driver tasks stamp each expected value with the cycle number in which it is due. The monitor samples the outputs 2 ns after the falling clock edge and compares only the entries due in that cycle. Each latency is therefore checked at its exact cycle. A check one cycle early confirms that no loss shows up before the third edge.

// File: rtl/i2c_arb_pkg.sv
`timescale 1ns/1ps
package i2c_arb_pkg;

  // What the local side is putting on SDA for the current bit slot
  typedef enum logic [1:0] {
    TXK_BIT    = 2'd0,
    TXK_RSTART = 2'd1,
    TXK_STOP   = 2'd2,
    TXK_NONE   = 2'd3
  } tx_kind_e;

  // Index of each bus line in the synchronizer array
  localparam int LINE_SDA = 0;
  localparam int LINE_SCL = 1;
  localparam int NLINES   = 2;

  // Number of distinct arbitration-loss patterns
  localparam int NLOSS = 4;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic level_q
);

  logic [STAGES-1:0] pipe_q, pipe_d;
  logic              hist_q, hist_d;

  // Next state: shift the raw line in, keep one cycle of history
  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], line_in};
    hist_d = pipe_q[STAGES-1];
  end

  // Idle bus lines are high, so reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      hist_q <= 1'b1;
    end else begin
      pipe_q <= pipe_d;
      hist_q <= hist_d;
    end
  end

  assign level   = pipe_q[STAGES-1];
  assign level_q = hist_q;

endmodule

// File: rtl/i2c_arb_detect.sv
`timescale 1ns/1ps
module i2c_arb_detect
  import i2c_arb_pkg::*;
(
  input  logic             sda_lvl,
  input  logic             sda_prev,
  input  logic             scl_lvl,
  input  logic             scl_prev,
  input  tx_kind_e         kind,
  input  logic             tx_bit,
  input  logic             master_mode,
  output logic [NLOSS-1:0] loss_hit,
  output logic             start_cond
);

  logic scl_rise, scl_fall, sda_fall;
  logic send_one, send_rs, send_sp;

  always_comb begin
    scl_rise   = scl_lvl & ~scl_prev;
    scl_fall   = ~scl_lvl & scl_prev;
    sda_fall   = ~sda_lvl & sda_prev;
    // start: SDA drops while SCL was high before and after
    start_cond = sda_fall & scl_lvl & scl_prev;

    send_one = (kind == TXK_BIT) & tx_bit;
    send_rs  = (kind == TXK_RSTART);
    send_sp  = (kind == TXK_STOP);

    // Data 1 or repeated start, but SDA found low at SCL rise
    loss_hit[0] = (send_one | send_rs) & scl_rise & ~sda_lvl;
    // Data 1 cut into by another device's repeated start
    loss_hit[1] = send_one & start_cond;
    // Own repeated start pre-empted: SCL pulled low before SDA went low
    loss_hit[2] = master_mode & send_rs & scl_fall & sda_lvl;
    // Own stop blocked: SDA held low by another device through the SCL high phase
    loss_hit[3] = master_mode & send_sp & scl_fall & ~sda_lvl;
  end

endmodule

// File: rtl/i2c_txact_ctrl.sv
`timescale 1ns/1ps
module i2c_txact_ctrl
  import i2c_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic             send_start,
  input  logic             send_stop,
  input  logic             clr_txact,
  input  logic             clr_arbloss,
  input  logic [NLOSS-1:0] loss_hit,
  input  logic             start_cond,
  output logic             tx_active,
  output logic             arb_lost,
  output logic             start_det
);

  logic txa_q, txa_d;
  logic arb_q, arb_d;
  logic std_q, std_d;
  logic set_req, clr_req, arb_set;

  always_comb begin
    set_req = dat_wr | send_start | send_stop;
    clr_req = dat_rd | clr_txact;
    // a loss pattern only counts while transmitting
    arb_set = txa_q & (|loss_hit);

    arb_d = arb_q;
    if (arb_set)          arb_d = 1'b1;
    else if (clr_arbloss) arb_d = 1'b0;

    txa_d = txa_q;
    if (arb_set || arb_q) txa_d = 1'b0;
    else if (set_req)     txa_d = 1'b1;
    else if (clr_req)     txa_d = 1'b0;

    std_d = start_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txa_q <= 1'b0;
      arb_q <= 1'b0;
      std_q <= 1'b0;
    end else begin
      txa_q <= txa_d;
      arb_q <= arb_d;
      std_q <= std_d;
    end
  end

  assign tx_active = txa_q;
  assign arb_lost  = arb_q;
  assign start_det = std_q;

  AST_TXA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !arb_lost && !(|loss_hit)) |=> tx_active); // R2
  AST_TXA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !tx_active); // R3
  AST_ARB_NEEDS_TXA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(tx_active)); // R5
  AST_ARB_EXCLUDES_TXA: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !tx_active); // R10
  AST_ARB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_arbloss && !(tx_active && |loss_hit)) |=> !arb_lost); // R11
  AST_ARB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !clr_arbloss) |=> arb_lost); // R11

endmodule

// File: rtl/i2c_arb_tracker.sv
`timescale 1ns/1ps
module i2c_arb_tracker
  import i2c_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic [1:0] tx_kind,
  input  logic       tx_bit,
  input  logic       master_mode,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic       send_start,
  input  logic       send_stop,
  input  logic       clr_txact,
  input  logic       clr_arbloss,
  output logic       sda_pull,
  output logic       tx_active,
  output logic       arb_lost,
  output logic       start_det
);

  // Reset: asserted asynchronously, released through a short pipeline
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[RST_STAGES-1];

  // Line synchronizers
  logic [NLINES-1:0] raw_lines, lvl, prv;
  assign raw_lines[LINE_SDA] = sda_in;
  assign raw_lines[LINE_SCL] = scl_in;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .line_in (raw_lines[g]),
      .level   (lvl[g]),
      .level_q (prv[g])
    );
  end

  tx_kind_e         kind;
  logic [NLOSS-1:0] loss_hit;
  logic             start_cond;
  logic             want_low;

  assign kind = tx_kind_e'(tx_kind);

  i2c_arb_detect u_detect (
    .sda_lvl     (lvl[LINE_SDA]),
    .sda_prev    (prv[LINE_SDA]),
    .scl_lvl     (lvl[LINE_SCL]),
    .scl_prev    (prv[LINE_SCL]),
    .kind        (kind),
    .tx_bit      (tx_bit),
    .master_mode (master_mode),
    .loss_hit    (loss_hit),
    .start_cond  (start_cond)
  );

  i2c_txact_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .dat_wr      (dat_wr),
    .dat_rd      (dat_rd),
    .send_start  (send_start),
    .send_stop   (send_stop),
    .clr_txact   (clr_txact),
    .clr_arbloss (clr_arbloss),
    .loss_hit    (loss_hit),
    .start_cond  (start_cond),
    .tx_active   (tx_active),
    .arb_lost    (arb_lost),
    .start_det   (start_det)
  );

  // SDA drive: what the local side wants low in this bit slot
  always_comb begin
    case (kind)
      TXK_BIT:    want_low = ~tx_bit;
      TXK_RSTART: want_low = lvl[LINE_SCL];
      TXK_STOP:   want_low = ~lvl[LINE_SCL];
      default:    want_low = 1'b0;
    endcase
  end

  assign sda_pull = tx_active & want_low;

  AST_START_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_s_n)
    start_det |-> $past(lvl[LINE_SCL])); // R7
  AST_LOSS_CLEARS_PULL: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(arb_lost) |-> !sda_pull); // R10

endmodule

// File: tb/i2c_arb_tracker_tb.sv
`timescale 1ns/1ps
module i2c_arb_tracker_tb;

  localparam int SIG_TXA = 0, SIG_ARB = 1, SIG_PULL = 2, SIG_START = 3;

  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_in = 1'b1, scl_in = 1'b0;
  logic [1:0] tx_kind = 2'd0;
  logic tx_bit = 1'b1, master_mode = 1'b0;
  logic dat_wr = 1'b0, dat_rd = 1'b0, send_start = 1'b0, send_stop = 1'b0;
  logic clr_txact = 1'b0, clr_arbloss = 1'b0;
  logic sda_pull, tx_active, arb_lost, start_det;

  int cyc = 0;
  int n_tests = 0, n_fail = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  i2c_arb_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
    .tx_kind(tx_kind), .tx_bit(tx_bit), .master_mode(master_mode),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .send_start(send_start), .send_stop(send_stop),
    .clr_txact(clr_txact), .clr_arbloss(clr_arbloss),
    .sda_pull(sda_pull), .tx_active(tx_active), .arb_lost(arb_lost), .start_det(start_det)
  );

  task automatic expect_at(input int dly, input int sig, input logic val, input string tag);
    exp_t e;
    e.due = cyc + dly; e.sig = sig; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: sample away from the edge, compare what is due now
  always @(negedge clk) begin
    #2;
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].due == cyc) begin
        logic act;
        case (exp_q[i].sig)
          SIG_TXA:  act = tx_active;
          SIG_ARB:  act = arb_lost;
          SIG_PULL: act = sda_pull;
          default:  act = start_det;
        endcase
        n_tests++;
        if (act !== exp_q[i].val) begin
          n_fail++;
          $display("FAIL %s sig=%0d cycle=%0d actual=%b expected=%b",
                   exp_q[i].tag, exp_q[i].sig, cyc, act, exp_q[i].val);
        end
        exp_q.delete(i);
      end
    end
  end

  // One collision scenario: settle lines, arm, change one line, check
  task automatic scen(input logic [1:0] k, input logic b, input logic m,
                      input logic c0, input logic d0, input logic c1, input logic d1,
                      input logic txon, input logic exp_loss, input logic exp_st,
                      input logic clr_same, input string tag);
    logic pexp;
    tx_kind = k; tx_bit = b; master_mode = m;
    scl_in = c0; sda_in = d0;
    tick(5);
    expect_at(0, SIG_PULL, 1'b0, "R4");
    case (k)
      2'd0:    pexp = ~b;
      2'd1:    pexp = c0;
      2'd2:    pexp = ~c0;
      default: pexp = 1'b0;
    endcase
    if (txon) begin
      send_start = 1'b1;
      expect_at(1, SIG_TXA, 1'b1, "R2");
      expect_at(1, SIG_PULL, pexp, "R4");
      tick(1);
      send_start = 1'b0;
      tick(1);
    end
    scl_in = c1; sda_in = d1;
    expect_at(2, SIG_ARB, 1'b0, "R12");
    expect_at(3, SIG_ARB, exp_loss, tag);
    expect_at(3, SIG_TXA, txon & ~exp_loss, "R10");
    expect_at(3, SIG_START, exp_st, "R7");
    if (clr_same) begin
      tick(2);
      clr_arbloss = 1'b1;   // lands on the same edge as the loss (R11)
      tick(1);
      clr_arbloss = 1'b0;
      tick(3);
    end else begin
      tick(6);
    end
    if (exp_loss) begin
      dat_wr = 1'b1;
      expect_at(1, SIG_TXA, 1'b0, "R10");
      tick(1);
      dat_wr = 1'b0;
      tick(1);
    end
    clr_arbloss = 1'b1; clr_txact = 1'b1;
    expect_at(1, SIG_ARB, 1'b0, "R11");
    expect_at(1, SIG_TXA, 1'b0, "R3");
    tick(1);
    clr_arbloss = 1'b0; clr_txact = 1'b0;
    scl_in = 1'b0; sda_in = 1'b1;
    tick(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(4);
    // R1: reset state
    expect_at(0, SIG_TXA, 1'b0, "R1");
    expect_at(0, SIG_ARB, 1'b0, "R1");
    expect_at(0, SIG_PULL, 1'b0, "R1");
    expect_at(0, SIG_START, 1'b0, "R1");
    tick(1);

    // R2 / R3: strobes
    dat_wr = 1'b1; expect_at(1, SIG_TXA, 1'b1, "R2"); tick(1); dat_wr = 1'b0; tick(1);
    dat_rd = 1'b1; expect_at(1, SIG_TXA, 1'b0, "R3"); tick(1); dat_rd = 1'b0; tick(1);
    send_stop = 1'b1; expect_at(1, SIG_TXA, 1'b1, "R2"); tick(1); send_stop = 1'b0; tick(1);
    clr_txact = 1'b1; expect_at(1, SIG_TXA, 1'b0, "R3"); tick(1); clr_txact = 1'b0; tick(1);
    dat_wr = 1'b1; clr_txact = 1'b1; expect_at(1, SIG_TXA, 1'b1, "R3");
    tick(1); dat_wr = 1'b0; clr_txact = 1'b0;
    tx_bit = 1'b0; expect_at(0, SIG_PULL, 1'b1, "R4"); tick(1);
    tx_kind = 2'd3; expect_at(0, SIG_PULL, 1'b0, "R4"); tick(1);
    tx_kind = 2'd0; tx_bit = 1'b1;
    clr_txact = 1'b1; expect_at(1, SIG_TXA, 1'b0, "R3"); tick(1); clr_txact = 1'b0; tick(2);

    //     kind  b     m     c0    d0    c1    d1    txon  loss  st    clr
    scen(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    scen(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    scen(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    scen(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    scen(2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    scen(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    scen(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    scen(2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    scen(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    scen(2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    scen(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    scen(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R11");

    tick(5);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R12 pending=%0d expected=0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule